// File: doc/BRIEF.md
# Clock and Reset Controller Register Stub

This block is the software-visible register face of a power, clock and reset controller. It holds configuration words for one crystal oscillator and three PLLs (core, memory, Ethernet), a core clock selector, a per-device reset word and a clock multiplexer status word. No analog hardware sits behind it. The oscillator always reports ready, and each PLL always reports lock with internal feedback chosen. Boot firmware that polls those bits therefore runs straight through.

Access is through a plain 32-bit register port. The port has a request strobe, a write flag, a byte address inside a 4 KiB window, a size code, write data and read data. Read data is combinational in the cycle of the request. A write lands on the next rising clock edge. Any access that hits no register, or that is not a full word, changes nothing. Such an access raises a one-cycle error pulse on the following cycle.

Top module: `crst_regs_stub`

## Requirements
- R1: After reset the oscillator word reads 0xC0000000. Each of the three PLL primary words reads 0x820187C1, which is bit 0, bits 10:6, bits 16:15, bit 25 and bit 31 set. The core clock selector reads 0x00000001. The two PLL secondary words, the device reset word and the mux status word read 0.
- R2: Registers sit at these byte offsets:
  - oscillator: 0x00
  - core PLL primary: 0x04
  - memory PLL primary: 0x0C
  - memory PLL secondary: 0x10
  - Ethernet PLL primary: 0x1C
  - Ethernet PLL secondary: 0x20
  - core clock selector: 0x24
  - device reset: 0x28
  - mux status: 0x2C

  The window is 4 KiB, using a 12-bit byte address.
- R3: A word write to the oscillator register stores the data with bit 31 (ready) forced to 1. Bit 30 (enable) and all other bits are kept as written.
- R4: A word write to any PLL primary word stores the data with bit 25 (internal feedback) and bit 31 (lock) forced to 1.
- R5: Word writes to the PLL secondary words, the core clock selector, the device reset word and the mux status word are stored unchanged. This includes bit 24 of a secondary word, which is its clock enable.
- R6: Read data follows the address combinationally in the same cycle. A write becomes visible to a read in the very next cycle.
- R7: A read from an offset holding no register returns 0. A write to such an offset changes no register. Misaligned offsets count as holding no register.
- R8: Only size code 2 (4 bytes) is valid. For any other code a read returns 0 and a write changes no register.
- R9: `err` is high for exactly the cycle after each request that hits no register or has a size code other than 2. It is low after idle cycles and after valid accesses.
- R10: Driving `rst_n` low restores every register to its R1 value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte address inside the window |
| size | input | 2 | log2 of access bytes; 2 = word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| err | output | 1 | One-cycle pulse after a rejected access |

## Verification
The error pulse of a rejected access lands in the same cycle as whatever access comes next. So a fault report and a valid read or write can overlap. The bench sends a rejected write and then, in the next cycle, a valid read of the same register. It judges that cycle on two points: `err` is high, and `rdata` still shows the untouched old value. One cycle later `err` must be low again. The bench also places a valid write right after a rejected one and checks that the valid write still lands.

// File: rtl/crst_pkg.sv
package crst_pkg;
  localparam int NREG      = 9;
  localparam int WORD_SIZE = 2;  // size code meaning 4 bytes

  // register order: 0 osc, 1 core pll a, 2 mem pll a, 3 mem pll b,
  // 4 eth pll a, 5 eth pll b, 6 core clk select, 7 dev reset, 8 mux status
  function automatic logic [11:0] reg_offset(input int idx);
    case (idx)
      0:       return 12'h000;
      1:       return 12'h004;
      2:       return 12'h00C;
      3:       return 12'h010;
      4:       return 12'h01C;
      5:       return 12'h020;
      6:       return 12'h024;
      7:       return 12'h028;
      default: return 12'h02C;
    endcase
  endfunction

  localparam logic [31:0] PLL_A_RST =
    32'h8000_0000 | 32'h0200_0000 | (32'h3 << 15) | (32'h1F << 6) | 32'h1;

  function automatic logic [31:0] reg_reset(input int idx);
    case (idx)
      0:         return 32'hC000_0000;
      1, 2, 4:   return PLL_A_RST;
      6:         return 32'h0000_0001;
      default:   return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] reg_force(input int idx);
    case (idx)
      0:         return 32'h8000_0000;
      1, 2, 4:   return 32'h8200_0000;
      default:   return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/crst_decode.sv
module crst_decode #(
  parameter int ADDR_W = 12,
  parameter int NREG   = crst_pkg::NREG
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   hit
);
  for (genvar i = 0; i < NREG; i++) begin : g_cmp
    assign hit[i] = (addr == ADDR_W'(crst_pkg::reg_offset(i)));
  end
endmodule

// File: rtl/crst_reg.sv
module crst_reg #(
  parameter int          W     = 32,
  parameter logic [31:0] RST   = '0,
  parameter logic [31:0] FORCE = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] d;

  always_comb begin
    d = wdata | W'(FORCE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= W'(RST);
    else if (we) q <= d;
  end
endmodule

// File: rtl/crst_fault.sv
module crst_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic size_ok,
  input  logic mapped,
  output logic err
);
  logic err_d;

  always_comb begin
    err_d = req && !(size_ok && mapped);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= err_d;
  end
endmodule

// File: rtl/crst_regs_stub.sv
module crst_regs_stub #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err
);
  localparam int NREG = crst_pkg::NREG;

  logic [NREG-1:0]   hit;
  logic [NREG-1:0]   we;
  logic [DATA_W-1:0] q [NREG];
  logic              size_ok;
  logic              acc_ok;
  logic              mapped;

  crst_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .addr (addr),
    .hit  (hit)
  );

  assign size_ok = (size == SIZE_W'(crst_pkg::WORD_SIZE));
  assign acc_ok  = req && size_ok;
  assign mapped  = |hit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    assign we[i] = acc_ok && wr && hit[i];
    crst_reg #(
      .W     (DATA_W),
      .RST   (crst_pkg::reg_reset(i)),
      .FORCE (crst_pkg::reg_force(i))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we[i]),
      .wdata (wdata),
      .q     (q[i])
    );
  end

  always_comb begin
    rdata = '0;
    if (acc_ok && !wr) begin
      for (int i = 0; i < NREG; i++) begin
        if (hit[i]) rdata = rdata | q[i];
      end
    end
  end

  crst_fault u_fault (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .size_ok (size_ok),
    .mapped  (mapped),
    .err     (err)
  );
endmodule

// File: rtl/crst_regs_stub_chk.sv
module crst_regs_stub_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SIZE_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [SIZE_W-1:0] size,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              err
);
  logic word_rd;
  assign word_rd = req && !wr && (size == SIZE_W'(2));

  assert_osc_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd && addr == ADDR_W'(12'h000) |-> rdata[31]);

  assert_pll_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_rd && (addr == ADDR_W'(12'h004) || addr == ADDR_W'(12'h00C) ||
                addr == ADDR_W'(12'h01C)) |-> rdata[31] && rdata[25]);

  assert_csel_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req && wr && size == SIZE_W'(2) && addr == ADDR_W'(12'h024) |=>
    (!(word_rd && addr == ADDR_W'(12'h024)) || rdata == $past(wdata)));

  assert_bad_size_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req && !wr && size != SIZE_W'(2) |-> rdata == '0);

  assert_err_on_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req && size != SIZE_W'(2) |=> err);

  assert_err_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !err);
endmodule

bind crst_regs_stub crst_regs_stub_chk #(
  .ADDR_W (ADDR_W), .DATA_W (DATA_W), .SIZE_W (SIZE_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .req (req), .wr (wr), .addr (addr),
  .size (size), .wdata (wdata), .rdata (rdata), .err (err)
);

// File: tb/crst_regs_stub_test.sv
module crst_regs_stub_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 29;

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic        eerr;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [31:0] PLLR = 32'h8201_87C1;

  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 2'd2, 32'h0, 32'hC000_0000, 1'b0, 8'd1},  // R1
    '{1'b0, 12'h004, 2'd2, 32'h0, PLLR,          1'b0, 8'd1},  // R1 R2
    '{1'b0, 12'h00C, 2'd2, 32'h0, PLLR,          1'b0, 8'd1},
    '{1'b0, 12'h01C, 2'd2, 32'h0, PLLR,          1'b0, 8'd1},
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'h0,         1'b0, 8'd1},
    '{1'b0, 12'h024, 2'd2, 32'h0, 32'h1,         1'b0, 8'd1},
    '{1'b0, 12'h02C, 2'd2, 32'h0, 32'h0,         1'b0, 8'd1},
    '{1'b1, 12'h000, 2'd2, 32'h0000_1234, 32'h0, 1'b0, 8'd3},  // R3
    '{1'b0, 12'h000, 2'd2, 32'h0, 32'h8000_1234, 1'b0, 8'd3},  // R3 R6
    '{1'b1, 12'h004, 2'd2, 32'h0000_0042, 32'h0, 1'b0, 8'd4},  // R4
    '{1'b0, 12'h004, 2'd2, 32'h0, 32'h8200_0042, 1'b0, 8'd4},
    '{1'b1, 12'h01C, 2'd2, 32'h7DFF_FFFF, 32'h0, 1'b0, 8'd4},
    '{1'b0, 12'h01C, 2'd2, 32'h0, 32'hFFFF_FFFF, 1'b0, 8'd4},
    '{1'b1, 12'h010, 2'd2, 32'h0100_0000, 32'h0, 1'b0, 8'd5},  // R5
    '{1'b0, 12'h010, 2'd2, 32'h0, 32'h0100_0000, 1'b0, 8'd5},
    '{1'b1, 12'h028, 2'd2, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'd5},
    '{1'b0, 12'h028, 2'd2, 32'h0, 32'hDEAD_BEEF, 1'b0, 8'd5},
    '{1'b1, 12'h02C, 2'd2, 32'h5A5A_0000, 32'h0, 1'b0, 8'd5},
    '{1'b0, 12'h02C, 2'd2, 32'h0, 32'h5A5A_0000, 1'b0, 8'd5},
    '{1'b0, 12'h008, 2'd2, 32'h0, 32'h0,         1'b1, 8'd7},  // R7
    '{1'b1, 12'h008, 2'd2, 32'h1111_1111, 32'h0, 1'b1, 8'd7},
    '{1'b0, 12'h00C, 2'd2, 32'h0, PLLR,          1'b0, 8'd7},
    '{1'b0, 12'hFFC, 2'd2, 32'h0, 32'h0,         1'b1, 8'd7},
    '{1'b0, 12'h002, 2'd2, 32'h0, 32'h0,         1'b1, 8'd7},
    '{1'b1, 12'h024, 2'd1, 32'h0, 32'h0,         1'b1, 8'd8},  // R8
    '{1'b0, 12'h024, 2'd2, 32'h0, 32'h1,         1'b0, 8'd8},
    '{1'b0, 12'h024, 2'd0, 32'h0, 32'h0,         1'b1, 8'd8},
    '{1'b1, 12'h020, 2'd2, 32'h00FF_00FF, 32'h0, 1'b0, 8'd5},
    '{1'b0, 12'h020, 2'd2, 32'h0, 32'h00FF_00FF, 1'b0, 8'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic        wr;
  logic [11:0] addr;
  logic [1:0]  size;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crst_regs_stub uut (
    .clk (clk), .rst_n (rst_n), .req (req), .wr (wr), .addr (addr),
    .size (size), .wdata (wdata), .rdata (rdata), .err (err)
  );

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic r, input logic w, input logic [11:0] a,
                       input logic [1:0] s, input logic [31:0] d);
    req = r; wr = w; addr = a; size = s; wdata = d;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(1'b0, 1'b0, 12'h0, 2'd2, 32'h0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 err idle after reset", {31'b0, err}, 32'h0);
    check("R9 rdata idle", rdata, 32'h0);
    rst_n = 1'b1;

    // table walk: R1..R8 and R9 pulse after each entry
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(1'b1, VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
      #1;
      if (!VECS[i].wr)
        check($sformatf("R%0d read vec %0d", VECS[i].rq, i), rdata, VECS[i].exp);
      @(posedge clk);
      #1;
      check($sformatf("R9 err after vec %0d", i), {31'b0, err},
            {31'b0, VECS[i].eerr});
    end

    // R6: combinational read, address changed twice inside one low phase
    @(negedge clk);
    drive(1'b1, 1'b0, 12'h028, 2'd2, 32'h0);
    #1 check("R6 comb read dev reset", rdata, 32'hDEAD_BEEF);
    drive(1'b1, 1'b0, 12'h010, 2'd2, 32'h0);
    #1 check("R6 comb read mem pll b", rdata, 32'h0100_0000);

    // R9 concurrency: rejected write, then valid read of same register
    @(negedge clk);
    drive(1'b1, 1'b1, 12'h028, 2'd3, 32'h0000_0000);
    @(negedge clk);
    drive(1'b1, 1'b0, 12'h028, 2'd2, 32'h0);
    #1;
    check("R9 err with next read", {31'b0, err}, 32'h1);
    check("R8 reg kept during err", rdata, 32'hDEAD_BEEF);
    @(negedge clk);
    check("R9 err single cycle", {31'b0, err}, 32'h0);
    // rejected write followed by valid write
    drive(1'b1, 1'b1, 12'h02C, 2'd0, 32'h0);
    @(negedge clk);
    drive(1'b1, 1'b1, 12'h02C, 2'd2, 32'h0000_0077);
    @(negedge clk);
    drive(1'b1, 1'b0, 12'h02C, 2'd2, 32'h0);
    #1 check("R5 write after rejected one", rdata, 32'h0000_0077);
    drive(1'b0, 1'b0, 12'h000, 2'd2, 32'h0);
    @(negedge clk);
    check("R9 err low after idle", {31'b0, err}, 32'h0);

    // R10: asynchronous reset mid-run, away from a clock edge
    #2 rst_n = 1'b0;
    drive(1'b1, 1'b0, 12'h028, 2'd2, 32'h0);
    #1 check("R10 dev reset cleared", rdata, 32'h0);
    drive(1'b1, 1'b0, 12'h004, 2'd2, 32'h0);
    #1 check("R10 core pll restored", rdata, PLLR);
    drive(1'b1, 1'b0, 12'h000, 2'd2, 32'h0);
    #1 check("R10 osc restored", rdata, 32'hC000_0000);
    drive(1'b1, 1'b0, 12'h024, 2'd2, 32'h0);
    #1 check("R10 clk select restored", rdata, 32'h1);
    drive(1'b0, 1'b0, 12'h000, 2'd2, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 err low after reset", {31'b0, err}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule